// File: doc/BRIEF.md
# Store Buffer with Address-Checked Load Bypass

This block sits between one in-order processor and a single shared memory port. Processor stores go into a four-entry queue, so the processor moves on at once instead of waiting for the memory write. The queue writes its entries to memory oldest first. It retires at most one entry every six cycles. A processor load may go to memory ahead of older queued stores, but only when its full address differs from every pending entry. A load whose address is still queued waits until that entry has been written. It then reads memory, and no data is forwarded from the queue. A strict mode makes each store wait for a memory acknowledgement before the next store is released.

Draining is run by a three-state machine. In `DR_COUNT` the retire counter advances on every cycle the queue holds an entry. When the counter reaches the end of the interval, the transition *interval elapsed* moves the machine to `DR_DUE`. There the head entry is offered as a write. On the write handshake, the transition *write accepted* goes back to `DR_COUNT` with the counter cleared. In strict mode the same handshake goes instead to `DR_ACKWAIT`. From `DR_ACKWAIT`, the transition *acknowledge seen* returns to `DR_COUNT`. A load that may bypass always takes the port before a due write. While the load holds the port, the machine stays in `DR_DUE`.

Top module: `wbuf_bypass`

## Requirements
- R1: While fewer than four entries are pending, `st_ready` is high whatever the memory port is doing. Each accepted store adds one to `occupancy` at the next clock edge.
- R2: Stores reach memory in the order they were accepted, each with its own address and data, and a write is offered only when at least one entry is pending.
- R3: A load whose 32-bit address equals no pending entry is put on the memory port in the same cycle (`mem_valid`=1, `mem_we`=0, `mem_addr`=load address), ahead of older stores. It completes when `mem_ready` is high, with `ld_ready`=1 and `ld_rdata` taken from `mem_rdata`.
- R4: A load whose address equals any pending entry is held, with `ld_ready` low and no read on the port, until that entry has been written. It then reads memory.
- R5: The head write is first offered five clock edges after the edge on which the queue became non-empty, and stays offered until accepted. With memory always ready and the queue never empty, write handshakes are exactly six cycles apart, and never closer.
- R6: At four pending entries, `full` is high and `st_ready` is low. A store presented then is not taken, and `occupancy` stays at four.
- R7: With `strict_mode` high, after a write handshake no further write is offered until a `mem_wack` pulse is seen. Counting for the next entry starts after that pulse.
- R8: When a bypassing load and a due write want the port in the same cycle, the load is issued. The write stays offered and goes out in the next cycle the port is free.
- R9: Reset empties the queue (`occupancy`=0, `full`=0), removes any memory request, and clears the retire counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_mode | input | 1 | 1 = wait for write acknowledge between stores |
| st_valid | input | 1 | Processor store request |
| st_ready | output | 1 | Store accepted this cycle when valid |
| st_addr | input | 32 | Store address |
| st_data | input | 32 | Store data |
| ld_valid | input | 1 | Processor load request |
| ld_ready | output | 1 | Load completes this cycle |
| ld_addr | input | 32 | Load address |
| ld_rdata | output | 32 | Load result |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid in the accept cycle |
| mem_wack | input | 1 | Write acknowledge pulse (used in strict mode) |
| occupancy | output | 3 | Number of pending entries |
| full | output | 1 | Queue holds four entries |

## Verification
The bench probes bypass against the oldest, the newest and a middle queued entry. It also uses an address that matches a queued one only in its low bits, so a design that compares too few address bits would wrongly stall or wrongly bypass. It measures the exact edge of the first retirement and the six-cycle spacing. An off-by-one counter, or one that keeps running while a load holds the port, shows up as a shifted or lost write. It checks that a store is refused when the queue is full. It checks that in strict mode no second write leaves before the acknowledge, that a reset in mid-operation drops every entry, and that a load colliding with a due write goes first without losing that write.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
    // drain machine: waiting out the interval, head write offered, awaiting acknowledge
    typedef enum logic [1:0] {
        DR_COUNT   = 2'd0,
        DR_DUE     = 2'd1,
        DR_ACKWAIT = 2'd2
    } drain_state_e;
endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    input  logic [AW-1:0] probe_addr,
    output logic          probe_hit,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    logic [AW-1:0]    addr_q [DEPTH];
    logic [DW-1:0]    data_q [DEPTH];
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] match;
    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    level_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q   <= '0;
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            level_q <= '0;
        end else begin
            if (push) begin
                addr_q[wr_ptr] <= push_addr;
                data_q[wr_ptr] <= push_data;
                vld_q[wr_ptr]  <= 1'b1;
                wr_ptr         <= bump(wr_ptr);
            end
            if (pop) begin
                vld_q[rd_ptr] <= 1'b0;
                rd_ptr        <= bump(rd_ptr);
            end
            level_q <= level_q + CW'(push) - CW'(pop);
        end
    end

    // one comparator per slot, every valid slot takes part
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = vld_q[g] && (addr_q[g] == probe_addr);
    end

    assign probe_hit = |match;
    assign head_addr = addr_q[rd_ptr];
    assign head_data = data_q[rd_ptr];
    assign level     = level_q;
    assign full      = (level_q == CW'(DEPTH));
    assign empty     = (level_q == '0);

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full && !pop |=> level == CW'(DEPTH)); // R6
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> vld_q != '0); // R2
endmodule

// File: rtl/wbuf_drain_ctrl.sv
module wbuf_drain_ctrl
    import wbuf_pkg::*;
#(
    parameter int GAP  = 6,
    localparam int CNTW = $clog2(GAP),
    localparam int SW   = $clog2(GAP + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strict,
    input  logic buf_empty,
    input  logic port_taken,
    input  logic mem_ready,
    input  logic wack,
    output logic drain_req,
    output logic drain_done
);
    drain_state_e  state_q, state_d;
    logic [CNTW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DR_COUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            DR_COUNT: begin
                if (!buf_empty) begin
                    if (cnt_q == CNTW'(GAP - 2)) begin
                        state_d = DR_DUE;       // interval elapsed
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + CNTW'(1);
                    end
                end
            end
            DR_DUE: begin
                if (drain_done) begin
                    state_d = strict ? DR_ACKWAIT : DR_COUNT; // write accepted
                end
            end
            DR_ACKWAIT: begin
                if (wack) begin
                    state_d = DR_COUNT;         // acknowledge seen
                end
            end
            default: begin
                state_d = DR_COUNT;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        drain_req  = (state_q == DR_DUE);
        drain_done = drain_req && !port_taken && mem_ready;
    end

    // spacing monitor: cycles since the last write handshake
    logic [SW-1:0] since_q;
    always_ff @(posedge clk) begin
        if (!rst_n)          since_q <= SW'(GAP);
        else if (drain_done) since_q <= '0;
        else if (since_q != SW'(GAP)) since_q <= since_q + SW'(1);
    end

    AST_RETIRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        drain_done |-> since_q >= SW'(GAP - 1)); // R5
    AST_DUE_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        drain_req |-> !buf_empty); // R2
endmodule

// File: rtl/wbuf_bypass.sv
module wbuf_bypass #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int GAP   = 6,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strict_mode,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          ld_valid,
    output logic          ld_ready,
    input  logic [AW-1:0] ld_addr,
    output logic [DW-1:0] ld_rdata,
    output logic          mem_valid,
    input  logic          mem_ready,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_wack,
    output logic [CW-1:0] occupancy,
    output logic          full
);
    logic          push, pop, hit, q_full, q_empty, load_go, drain_req;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data;

    wbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_addr  (st_addr),
        .push_data  (st_data),
        .pop        (pop),
        .head_addr  (head_addr),
        .head_data  (head_data),
        .probe_addr (ld_addr),
        .probe_hit  (hit),
        .level      (occupancy),
        .full       (q_full),
        .empty      (q_empty)
    );

    wbuf_drain_ctrl #(.GAP(GAP)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .strict     (strict_mode),
        .buf_empty  (q_empty),
        .port_taken (load_go),
        .mem_ready  (mem_ready),
        .wack       (mem_wack),
        .drain_req  (drain_req),
        .drain_done (pop)
    );

    always_comb begin
        load_go   = ld_valid && !hit;
        st_ready  = !q_full;
        push      = st_valid && !q_full;
        full      = q_full;
        mem_valid = load_go || drain_req;
        mem_we    = !load_go && drain_req;
        mem_addr  = load_go ? ld_addr : head_addr;
        mem_wdata = head_data;
        ld_ready  = load_go && mem_ready;
        ld_rdata  = mem_rdata;
    end

    // strict-mode outstanding-write tracker
    logic out_q;
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else if (mem_valid && mem_ready && mem_we && strict_mode) out_q <= 1'b1;
        else if (mem_wack) out_q <= 1'b0;
    end

    AST_STRICT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_q |-> !(mem_valid && mem_we)); // R7
    AST_BYPASS_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_we |-> !hit && mem_addr == ld_addr); // R3
    AST_LOAD_FIRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        drain_req && load_go |=> drain_req); // R8
    AST_STORE_COUNTED: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid && st_ready && !pop |=> occupancy != '0); // R1
    AST_WRITE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_we |-> occupancy != '0); // R2
endmodule

// File: tb/wbuf_bypass_tb.sv
module wbuf_bypass_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n, strict_mode;
    logic        st_valid, st_ready, ld_valid, ld_ready;
    logic [31:0] st_addr, st_data, ld_addr, ld_rdata;
    logic        mem_valid, mem_ready, mem_we, mem_wack, full;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [2:0]  occupancy;

    always #(CLK_P/2) clk = ~clk;

    wbuf_bypass u_dut (
        .clk(clk), .rst_n(rst_n), .strict_mode(strict_mode),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_rdata(ld_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_wack(mem_wack),
        .occupancy(occupancy), .full(full)
    );

    // memory model with write log
    logic [31:0] mem_arr   [0:15];
    logic [31:0] wlog_addr [0:31];
    logic [31:0] wlog_data [0:31];
    int          wlog_cyc  [0:31];
    int          wn, cyc;
    assign mem_rdata = mem_arr[mem_addr[5:2]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem_arr[i] <= 32'hF000_0000 | i;
        end else if (mem_valid && mem_ready && mem_we) begin
            mem_arr[mem_addr[5:2]] <= mem_wdata;
            wlog_addr[wn] <= mem_addr;
            wlog_data[wn] <= mem_wdata;
            wlog_cyc[wn]  <= cyc;
            wn <= wn + 1;
        end
    end
    initial begin cyc = 0; wn = 0; end

    int tests = 0, fails = 0;
    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic nx();
        @(negedge clk);
        #1;
    endtask

    // load probe vectors: {address, 1 = may bypass}; queue holds 0x10,0x14,0x18,0x1C
    localparam logic [32:0] VEC [0:6] = '{
        {32'h0000_0010, 1'b0},
        {32'h0000_001C, 1'b0},
        {32'h0000_0020, 1'b1},
        {32'h0000_0014, 1'b0},
        {32'h0000_1010, 1'b1},
        {32'h0000_0000, 1'b1},
        {32'h0000_0018, 1'b0}
    };

    initial begin
        #(CLK_P * 100000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base;
        rst_n = 0; strict_mode = 0; st_valid = 0; st_addr = 0; st_data = 0;
        ld_valid = 0; ld_addr = 0; mem_ready = 0; mem_wack = 0;
        repeat (3) nx();
        rst_n = 1;
        nx();
        // R9 reset state
        chk("R9 occupancy", {29'd0, occupancy}, 0);
        chk("R9 full", {31'd0, full}, 0);
        chk("R9 mem_valid", {31'd0, mem_valid}, 0);

        // R1 / R5: single store with memory stalled
        st_valid = 1; st_addr = 32'h04; st_data = 32'h11; #1;
        chk("R1 st_ready with memory busy", {31'd0, st_ready}, 1);
        nx(); st_valid = 0; #1;
        chk("R1 occupancy after store", {29'd0, occupancy}, 1);
        for (int k = 1; k <= 4; k++) begin
            nx();
            chk("R5 no early write", {31'd0, mem_valid}, 0);
        end
        nx();
        chk("R5 write offered on fifth edge", {31'd0, mem_valid && mem_we}, 1);
        chk("R5 write address", mem_addr, 32'h04);
        repeat (3) nx();
        chk("R5 write held while not ready", {31'd0, mem_valid && mem_we}, 1);
        mem_ready = 1; nx();
        chk("R2 write logged", wn, 1);
        chk("R2 queue empty", {29'd0, occupancy}, 0);

        // R6 fill with memory stalled, R3/R4 table
        mem_ready = 0;
        for (int k = 0; k < 4; k++) begin
            st_valid = 1; st_addr = 32'h10 + 4 * k; st_data = 32'hA0 + k;
            nx();
        end
        #1;
        chk("R6 full flag", {31'd0, full}, 1);
        chk("R6 st_ready low", {31'd0, st_ready}, 0);
        st_addr = 32'h3C; st_data = 32'hEE; nx();
        chk("R6 refused store", {29'd0, occupancy}, 4);
        st_valid = 0;
        for (int v = 0; v < 7; v++) begin
            ld_addr = VEC[v][32:1]; ld_valid = 1; #1;
            if (VEC[v][0]) begin
                chk("R3 bypass read issued", {31'd0, mem_valid && !mem_we}, 1);
                chk("R3 bypass address", mem_addr, VEC[v][32:1]);
            end else begin
                chk("R4 matching load held", {31'd0, ld_ready}, 0);
                chk("R4 no read issued", {31'd0, mem_valid && !mem_we}, 0);
            end
            ld_valid = 0; nx();
        end
        base = wn; mem_ready = 1;
        repeat (26) nx();
        chk("R2 four writes", wn - base, 4);
        for (int k = 0; k < 4; k++) begin
            chk("R2 order address", wlog_addr[base + k], 32'h10 + 4 * k);
            chk("R2 order data", wlog_data[base + k], 32'hA0 + k);
        end
        for (int k = 0; k < 3; k++)
            chk("R5 six-cycle spacing", wlog_cyc[base + k + 1] - wlog_cyc[base + k], 6);

        // R4 stall then memory read
        st_valid = 1; st_addr = 32'h24; st_data = 32'h55; nx();
        st_valid = 0; ld_valid = 1; ld_addr = 32'h24; #1;
        chk("R4 held while pending", {31'd0, ld_ready}, 0);
        for (int k = 1; k <= 5; k++) begin
            nx();
            chk("R4 held while pending", {31'd0, ld_ready}, 0);
        end
        nx();
        chk("R4 load after drain", {31'd0, ld_ready}, 1);
        chk("R4 load data from memory", ld_rdata, 32'h55);
        ld_valid = 0;

        // R8 load wins over due write
        nx();
        st_valid = 1; st_addr = 32'h28; st_data = 32'h66; nx();
        st_valid = 0;
        repeat (4) nx();
        nx();
        ld_valid = 1; ld_addr = 32'h30; #1;
        chk("R8 load takes port", {31'd0, mem_valid && !mem_we}, 1);
        chk("R8 load address", mem_addr, 32'h30);
        chk("R8 load completes", {31'd0, ld_ready}, 1);
        nx(); ld_valid = 0; #1;
        chk("R8 write still offered", {31'd0, mem_valid && mem_we}, 1);
        chk("R8 write address", mem_addr, 32'h28);
        nx();
        chk("R8 write done", wlog_addr[wn - 1], 32'h28);

        // R7 strict mode
        strict_mode = 1; base = wn;
        st_valid = 1; st_addr = 32'h34; st_data = 32'h77; nx();
        st_addr = 32'h38; st_data = 32'h88; nx();
        st_valid = 0;
        for (int k = 0; k < 20 && wn == base; k++) nx();
        chk("R7 first strict write", wn - base, 1);
        for (int k = 0; k < 15; k++) begin
            chk("R7 no write before ack", {31'd0, mem_valid && mem_we}, 0);
            nx();
        end
        mem_wack = 1; nx(); mem_wack = 0;
        repeat (8) nx();
        chk("R7 second write after ack", wn - base, 2);
        chk("R7 second address", wlog_addr[base + 1], 32'h38);
        mem_wack = 1; nx(); mem_wack = 0; strict_mode = 0; nx();

        // R9 reset in mid-operation
        mem_ready = 0;
        st_valid = 1; st_addr = 32'h08; nx(); st_addr = 32'h0C; nx(); st_valid = 0;
        repeat (3) nx();
        rst_n = 0; nx(); rst_n = 1; #1;
        chk("R9 occupancy cleared", {29'd0, occupancy}, 0);
        chk("R9 request dropped", {31'd0, mem_valid}, 0);
        st_valid = 1; st_addr = 32'h2C; nx(); st_valid = 0;
        repeat (4) nx();
        chk("R9 counter restarted", {31'd0, mem_valid}, 0);
        nx();
        chk("R9 write after full interval", {31'd0, mem_valid && mem_we}, 1);
        mem_ready = 1; nx();

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule